// File: doc/BRIEF.md
# Gated UART Transmitter

This block is the transmit half of a UART. Bytes arrive on a valid/ready write port. They wait in a 16-entry FIFO and then in a one-byte holding stage. From there they move into a serial shift register, which sends 8N1 frames on the TXD line. Bit timing comes from an external baud-tick pulse. The block does not generate baud rates itself.

A single transmit-enable flag controls only one thing: the transfer of the held byte into the shift register. External flow-control logic drives the flag with two one-cycle strobes. A clear strobe is typically raised when the peer's TX-permit line goes false or an XOFF (0x13) arrives. A set strobe is raised when the permit returns or an XON (0x11) arrives.

Clearing the flag never cuts a frame short. A character that has already started is always sent to the end of its stop bit. Bytes still waiting keep their order and stay in place until the flag is set again.

Top module: `uart_txgate_top`

## Requirements
- R1: The transmit-enable flag is 1 after reset. Bytes written after reset are sent without any set strobe.
- R2: Right after reset, `txd` is 1, `busy` is 0 and `wr_ready` is 1. `txd` is 1 whenever no character is being shifted.
- R3: While the flag is 1, bytes go out in the order they were written. Each new start bit follows the previous stop bit without an idle bit time, so consecutive start bits are at most 10 bit times plus 10 clock cycles apart.
- R4: A frame is one start bit at 0, then eight data bits with bit 0 first, then one stop bit at 1. Each bit lasts 16 `baud_tick` pulses.
- R5: A clear strobe that arrives while a character is being shifted does not shorten it. That character is sent in full, including its stop bit.
- R6: While the flag is 0, no new character starts. Queued bytes stay queued.
- R7: A set strobe resumes transmission with the oldest queued byte, and the remaining bytes follow in write order.
- R8: `busy` is 1 while a character is being shifted, or while bytes are queued and the flag is 1. Otherwise it is 0.
- R9: With the flag at 0 and the line idle, the block accepts exactly 17 bytes (16 in the FIFO and 1 in the holding stage). It then holds `wr_ready` at 0, and no accepted byte is lost.
- R10: The flag is looked at only in the cycle when a character would be loaded. A clear followed by a set, both inside one character, does not delay the next character.
- R11: `en_clr` high sets the flag to 0, and `en_set` high sets it to 1. When both are high in the same cycle, the flag becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| wr_valid | input | 1 | Write request |
| wr_data | input | 8 | Byte to send |
| wr_ready | output | 1 | Write accepted when high together with `wr_valid` |
| en_set | input | 1 | Strobe that sets the transmit-enable flag |
| en_clr | input | 1 | Strobe that clears the transmit-enable flag (has priority) |
| txd | output | 1 | Serial output, idles at 1 |
| busy | output | 1 | Character in flight, or bytes queued while enabled |

## Verification
The bench decodes every frame at mid-bit and checks its bit order and stop bit. It also records each start time, so both a late start and a frame that was cut short become visible. A design that aborts the character in flight on a clear strobe would produce a bad stop bit, or lose that byte. A design that lets the flag leak past the holding stage would send a frame while the flag is 0.

The bench pulses the flag low and back high inside one character. A design that latches the flag between loads instead of sampling it at load time would leave a gap between frames. The bench also fills the queue to its 17-byte capacity and raises both strobes in the same cycle. These two cases catch an off-by-one in the full detection and the wrong strobe priority.

// File: rtl/uart_txg_pkg.sv
package uart_txg_pkg;

    localparam int unsigned TXG_DATA_W      = 8;
    localparam int unsigned TXG_TICKS_PER_B = 16;
    localparam int unsigned TXG_FRAME_BITS  = TXG_DATA_W + 2;

    typedef logic [TXG_DATA_W-1:0]     txg_byte_t;
    typedef logic [TXG_FRAME_BITS-1:0] txg_frame_t;

    // One byte plus its occupancy flag, used by the holding stage.
    typedef struct packed {
        logic      valid;
        txg_byte_t data;
    } txg_slot_t;

    // Serial order is bit 0 first: start(0), data LSB..MSB, stop(1).
    function automatic txg_frame_t txg_make_frame(input txg_byte_t b);
        return {1'b1, b, 1'b0};
    endfunction

endpackage

// File: rtl/txg_fifo.sv
module txg_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     pop_data,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/txg_hold.sv
module txg_hold
    import uart_txg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fifo_empty,
    input  txg_byte_t fifo_data,
    input  logic      take,
    output logic      fifo_pop,
    output txg_slot_t slot
);
    // Refill whenever the slot is empty or is being handed on this cycle.
    assign fifo_pop = !fifo_empty && (!slot.valid || take);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (fifo_pop) begin
            slot <= '{valid: 1'b1, data: fifo_data};
        end else if (take) begin
            slot.valid <= 1'b0;
        end
    end
endmodule

// File: rtl/txg_shifter.sv
module txg_shifter
    import uart_txg_pkg::*;
#(
    parameter int unsigned TICKS = TXG_TICKS_PER_B,
    parameter int unsigned BITS  = TXG_FRAME_BITS,
    localparam int unsigned TICK_W = (TICKS > 1) ? $clog2(TICKS) : 1,
    localparam int unsigned IDX_W  = $clog2(BITS)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      baud_tick,
    input  logic      load,
    input  txg_byte_t load_data,
    output logic      active,
    output logic      txd
);
    txg_frame_t        frame_q;
    logic [TICK_W-1:0] tick_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic              bit_end;

    assign bit_end = baud_tick && (tick_cnt == TICK_W'(TICKS - 1));
    assign txd     = active ? frame_q[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            frame_q  <= '1;
            tick_cnt <= '0;
            bit_idx  <= '0;
        end else if (!active) begin
            if (load) begin
                active   <= 1'b1;
                frame_q  <= txg_make_frame(load_data);
                tick_cnt <= '0;
                bit_idx  <= '0;
            end
        end else if (baud_tick) begin
            tick_cnt <= bit_end ? '0 : tick_cnt + 1'b1;
            if (bit_end) begin
                frame_q <= {1'b1, frame_q[BITS-1:1]};
                if (bit_idx == IDX_W'(BITS - 1)) active <= 1'b0;
                else                             bit_idx <= bit_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_txgate_top.sv
module uart_txgate_top
    import uart_txg_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    output logic       wr_ready,
    input  logic       en_set,
    input  logic       en_clr,
    output logic       txd,
    output logic       busy
);
    logic             fifo_full, fifo_empty, fifo_pop, sh_active, sh_load;
    logic             gate_q;
    logic [CNT_W-1:0] fifo_count;
    txg_byte_t        fifo_head;
    txg_slot_t        hold;

    // Transmit-enable flag: clear has priority, comes up enabled.
    always_ff @(posedge clk) begin
        if (rst)         gate_q <= 1'b1;
        else if (en_clr) gate_q <= 1'b0;
        else if (en_set) gate_q <= 1'b1;
    end

    assign wr_ready = !fifo_full;
    // The flag matters only at the hand-off into the shift register.
    assign sh_load  = !sh_active && hold.valid && gate_q;
    assign busy     = sh_active || ((hold.valid || !fifo_empty) && gate_q);

    txg_fifo #(.DEPTH(FIFO_DEPTH), .W(TXG_DATA_W)) u_fifo (
        .clk(clk), .rst(rst),
        .push(wr_valid), .push_data(wr_data),
        .pop(fifo_pop), .pop_data(fifo_head),
        .full(fifo_full), .empty(fifo_empty), .count(fifo_count)
    );

    txg_hold u_hold (
        .clk(clk), .rst(rst),
        .fifo_empty(fifo_empty), .fifo_data(fifo_head),
        .take(sh_load), .fifo_pop(fifo_pop), .slot(hold)
    );

    txg_shifter u_shift (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .load(sh_load), .load_data(hold.data),
        .active(sh_active), .txd(txd)
    );
endmodule

// File: rtl/txg_checker.sv
module txg_checker #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             en_set,
    input logic             en_clr,
    input logic             wr_ready,
    input logic             txd,
    input logic             busy,
    input logic             sh_active,
    input logic             gate_q,
    input logic [CNT_W-1:0] fifo_count
);
    // R2
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        !sh_active |-> txd);

    // R5
    frame_ends_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sh_active) |-> $past(txd));

    // R6
    start_needs_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sh_active) |-> $past(gate_q));

    // R8
    busy_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
        sh_active |-> busy);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_ready |-> (fifo_count == CNT_W'(DEPTH)));

    // R11
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (en_set && en_clr) |=> !gate_q);
endmodule

bind uart_txgate_top txg_checker #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .en_set(en_set), .en_clr(en_clr),
    .wr_ready(wr_ready), .txd(txd), .busy(busy),
    .sh_active(sh_active), .gate_q(gate_q), .fifo_count(fifo_count)
);

// File: tb/uart_txgate_top_bench.sv
module uart_txgate_top_bench;
    localparam int BIT_CYC = 32;          // 16 ticks, one tick every 2 cycles
    localparam int MAX_GAP = 10 * BIT_CYC + 10;
    localparam int NVEC    = 4;
    localparam logic [7:0] VEC [NVEC] = '{8'h55, 8'hA3, 8'h00, 8'hFF};

    logic clk = 0, rst = 1, baud_tick = 0;
    logic wr_valid = 0, en_set = 0, en_clr = 0;
    logic [7:0] wr_data = 0;
    logic wr_ready, txd, busy;

    int total = 0, bad = 0, cyc = 0;
    int n_start = 0, n_dec = 0, frame_err = 0;
    logic [7:0] dec_byte [64];
    int dec_start [64];

    uart_txgate_top u_uart_txgate_top (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .en_set(en_set), .en_clr(en_clr), .txd(txd), .busy(busy)
    );

    always #2.5 clk = ~clk;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        baud_tick <= ~baud_tick;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Frame decoder: samples at mid-bit from the falling start edge.
    initial begin
        logic prev;
        logic [7:0] b;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (!rst && prev && !txd) begin
                dec_start[n_start] = cyc;
                n_start++;
                repeat (16) @(negedge clk);
                if (txd !== 1'b0) frame_err++;
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT_CYC) @(negedge clk);
                    b[i] = txd;
                end
                repeat (BIT_CYC) @(negedge clk);
                if (txd !== 1'b1) frame_err++;
                dec_byte[n_dec] = b;
                n_dec++;
            end
            prev = txd;
        end
    end

    task automatic put(input logic [7:0] d);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1; wr_data = d;
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic strobe(input logic s, input logic c);
        @(negedge clk);
        en_set = s; en_clr = c;
        @(negedge clk);
        en_set = 0; en_clr = 0;
    endtask

    task automatic wait_dec(input int n);
        for (int k = 0; k < 20000 && n_dec < n; k++) @(negedge clk);
    endtask

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base, acc, s0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R2 reset state
        check("R2 txd", txd, 1);
        check("R2 busy", busy, 0);
        check("R2 wr_ready", wr_ready, 1);

        // Table walk: R1 (no set strobe), R3, R4
        for (int i = 0; i < NVEC; i++) put(VEC[i]);
        check("R8 busy while queued", busy, 1);
        wait_dec(NVEC);
        for (int i = 0; i < NVEC; i++) check("R1/R3/R4 byte", dec_byte[i], VEC[i]);
        for (int i = 1; i < NVEC; i++)
            check("R3 back-to-back", int'(dec_start[i] - dec_start[i-1] <= MAX_GAP), 1);

        // R5/R6/R7: clear during a character
        base = n_dec;
        put(8'h3C); put(8'h81); put(8'h7E);
        while (n_start <= base) @(negedge clk);
        repeat (100) @(negedge clk);
        strobe(0, 1);
        repeat (800) @(negedge clk);
        check("R5 finished byte", dec_byte[base], 8'h3C);
        check("R6 no new start", n_start, base + 1);
        check("R8 busy low while gated", busy, 0);
        check("R2 line idle", txd, 1);
        strobe(1, 0);
        check("R8 busy after set", busy, 1);
        wait_dec(base + 3);
        check("R7 resume order 1", dec_byte[base+1], 8'h81);
        check("R7 resume order 2", dec_byte[base+2], 8'h7E);

        // R9: capacity with the gate closed
        base = n_dec;
        strobe(0, 1);
        acc = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            wr_valid = 0;
            if (!wr_ready) break;
            wr_valid = 1; wr_data = 8'h40 + 8'(acc);
            acc++;
        end
        @(negedge clk); wr_valid = 0;
        check("R9 accepted", acc, 17);
        check("R9 ready low", wr_ready, 0);
        check("R6 nothing sent while full", n_start, base);
        strobe(1, 0);
        wait_dec(base + 17);
        for (int i = 0; i < 17; i++) check("R9 drain", dec_byte[base+i], 8'h40 + i);

        // R10: short clear/set inside a character
        base = n_dec;
        put(8'hC5); put(8'h5A);
        while (n_start <= base) @(negedge clk);
        repeat (60) @(negedge clk);
        strobe(0, 1);
        repeat (20) @(negedge clk);
        strobe(1, 0);
        wait_dec(base + 2);
        s0 = dec_start[base+1] - dec_start[base];
        check("R10 no gap", int'(s0 <= MAX_GAP), 1);
        check("R10 byte", dec_byte[base+1], 8'h5A);

        // R11: both strobes at once leave the flag cleared
        base = n_dec;
        strobe(0, 1);
        put(8'h99);
        repeat (100) @(negedge clk);
        strobe(1, 1);
        repeat (400) @(negedge clk);
        check("R11 clear wins", n_start, base);
        strobe(1, 0);
        wait_dec(base + 1);
        check("R11 byte after set", dec_byte[base], 8'h99);

        check("R4 framing errors", frame_err, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule